// File: doc/BRIEF.md
# Lockable CMOS RAM with Century Rollover

This block is a 128-byte battery-backed register file that software reaches through a byte-wide index/data port pair. Software first writes an index, then reads or writes the data port. Two 8-byte windows of the array can each be sealed by a sticky lock bit. While a window is sealed, stores into it are dropped and loads from it return a fixed fill pattern. Only a hard reset or an RTC-well reset can release a lock.

The block also watches the BCD year byte. When software overwrites a stored 99h year with 00h, the block latches a century flag in its status register. When the system is awake it also pulses a one-cycle SMI request; when the system is asleep it does not. An RTC-well reset returns the lock and status bits to their defaults and raises a power-loss flag that firmware can read and clear. The array contents survive both kinds of reset.

Top module: `cmos_lock_ram`

## Requirements
- R1: A pulse on `idx_we` latches `host_wdata[6:0]` as the current index, and bit 7 is discarded. A pulse on `data_we` stores `host_wdata` at the current index. `host_rdata` shows the byte at the current index.
- R2: Window 0 covers indices 38h–3Fh and is governed by lock bit 0. Window 1 covers 78h–7Fh and is governed by lock bit 1. A lock on one window does not affect the other window or any index outside both windows.
- R3: A data write to an index inside a locked window leaves the stored byte unchanged.
- R4: While the current index lies inside a locked window, `host_rdata` reads FFh.
- R5: A `cfg_we` pulse ORs `cfg_wdata` into the lock bits, and `cfg_rdata` reports them. Writing 0 never clears a set lock bit.
- R6: A data write of 00h to index 09h while that byte holds 99h sets status bit 7 (century flag). Other year transitions, such as 98h→00h or 99h→01h, do not set it.
- R7: On such a rollover with `sleep_state` low, `smi_req` is high for exactly the one cycle after the write. With `sleep_state` high, no SMI request is produced.
- R8: Status bits 7 and 2 clear when `sts_we` is pulsed with a 1 in that bit position. A 0 in that position leaves the bit unchanged.
- R9: While `rtc_rst_n` is low, the lock bits and status bit 7 clear and status bit 2 (power-loss flag) sets. The array contents are kept.
- R10: While `hard_rst_n` is low, the lock bits and the index clear. The status bits and the array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Hard reset, active low, synchronous |
| rtc_rst_n | input | 1 | RTC-well reset, active low, synchronous |
| sleep_state | input | 1 | 1 = system in a sleep state, 0 = working |
| idx_we | input | 1 | Index register write strobe |
| data_we | input | 1 | Data port write strobe |
| host_wdata | input | 8 | Write data for index or data port |
| host_rdata | output | 8 | Data port read value |
| cfg_we | input | 1 | Lock register write strobe |
| cfg_wdata | input | 2 | Lock bits to set |
| cfg_rdata | output | 2 | Current lock bits |
| sts_we | input | 1 | Status write-one-to-clear strobe |
| sts_wdata | input | 8 | Status clear mask |
| sts_rdata | output | 8 | Status: bit 7 century flag, bit 2 power-loss flag |
| smi_req | output | 1 | One-cycle SMI request |

## Verification
The assertions check on every cycle that lock bits never drop outside a reset and that both resets leave the expected lock and status values. They also check that an SMI request is a single-cycle pulse, follows an awake cycle, and coincides with a set century flag. Only the bench scenarios can show that a locked window masks its reads and rejects its writes while leaving the other window untouched. The same holds for telling a true 99h→00h rollover apart from the near misses, and for confirming that the array contents survive both resets.

// File: rtl/cmos_lock_pkg.sv
package cmos_lock_pkg;
    localparam int AW     = 7;
    localparam int DW     = 8;
    localparam int NWIN   = 2;
    localparam int WIN_LG = 3;
    localparam int STS_CENT = 7;
    localparam int STS_PWR  = 2;

    // Window base indices; entry w is guarded by lock bit w
    localparam logic [NWIN-1:0][AW-1:0] WIN_BASE = {7'h78, 7'h38};
    localparam logic [AW-1:0] YEAR_IDX = 7'h09;
    localparam logic [DW-1:0] YEAR_LAST = 8'h99;
    localparam logic [DW-1:0] YEAR_FIRST = 8'h00;

    typedef struct packed {
        logic [AW-1:0]   idx;
        logic [NWIN-1:0] lock;
        logic            cent;
        logic            pwr;
        logic            smi;
    } ctl_t;
endpackage

// File: rtl/cmos_ram_array.sv
module cmos_ram_array #(
    parameter int AW  = 7,
    parameter int DW  = 8,
    parameter int TAP = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] tap_rdata
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] TAP_A = AW'(TAP);

    // No reset: contents persist across every reset
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata     = mem_q[addr];
    assign tap_rdata = mem_q[TAP_A];
endmodule

// File: rtl/cmos_win_decode.sv
module cmos_win_decode #(
    parameter int AW     = 7,
    parameter int NWIN   = 2,
    parameter int WIN_LG = 3,
    parameter logic [NWIN-1:0][AW-1:0] BASES = '0
) (
    input  logic [AW-1:0]   addr,
    output logic [NWIN-1:0] hit
);
    generate
        for (genvar w = 0; w < NWIN; w++) begin : g_win
            assign hit[w] = (addr[AW-1:WIN_LG] == BASES[w][AW-1:WIN_LG]);
        end
    endgenerate
endmodule

// File: rtl/cmos_lock_ram.sv
module cmos_lock_ram
    import cmos_lock_pkg::*;
#(
    parameter logic [7:0] LOCK_FILL = 8'hFF
) (
    input  logic       clk,
    input  logic       hard_rst_n,
    input  logic       rtc_rst_n,
    input  logic       sleep_state,
    input  logic       idx_we,
    input  logic       data_we,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       cfg_we,
    input  logic [1:0] cfg_wdata,
    output logic [1:0] cfg_rdata,
    input  logic       sts_we,
    input  logic [7:0] sts_wdata,
    output logic [7:0] sts_rdata,
    output logic       smi_req
);
    ctl_t st_q, st_d;

    logic [NWIN-1:0] win_hit;
    logic            blocked;
    logic            ram_we;
    logic [DW-1:0]   ram_rdata;
    logic [DW-1:0]   year_now;
    logic            rollover;

    cmos_win_decode #(
        .AW(AW), .NWIN(NWIN), .WIN_LG(WIN_LG), .BASES(WIN_BASE)
    ) u_dec (
        .addr (st_q.idx),
        .hit  (win_hit)
    );

    cmos_ram_array #(
        .AW(AW), .DW(DW), .TAP(int'(YEAR_IDX))
    ) u_ram (
        .clk       (clk),
        .we        (ram_we),
        .addr      (st_q.idx),
        .wdata     (host_wdata),
        .rdata     (ram_rdata),
        .tap_rdata (year_now)
    );

    assign blocked  = |(win_hit & st_q.lock);
    assign ram_we   = data_we & ~blocked;
    assign rollover = ram_we && (st_q.idx == YEAR_IDX)
                      && (year_now == YEAR_LAST) && (host_wdata == YEAR_FIRST);

    always_comb begin
        st_d     = st_q;
        st_d.smi = 1'b0;
        if (idx_we) begin
            st_d.idx = host_wdata[AW-1:0];
        end
        if (cfg_we) begin
            st_d.lock = st_q.lock | cfg_wdata;
        end
        if (sts_we) begin
            if (sts_wdata[STS_CENT]) st_d.cent = 1'b0;
            if (sts_wdata[STS_PWR])  st_d.pwr  = 1'b0;
        end
        if (rollover) begin
            st_d.cent = 1'b1;
            st_d.smi  = ~sleep_state;
        end
        if (!hard_rst_n) begin
            st_d.idx  = '0;
            st_d.lock = '0;
            st_d.smi  = 1'b0;
        end
        if (!rtc_rst_n) begin
            st_d.idx  = '0;
            st_d.lock = '0;
            st_d.cent = 1'b0;
            st_d.pwr  = 1'b1;
            st_d.smi  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        sts_rdata           = '0;
        sts_rdata[STS_CENT] = st_q.cent;
        sts_rdata[STS_PWR]  = st_q.pwr;
    end

    assign host_rdata = blocked ? LOCK_FILL : ram_rdata;
    assign cfg_rdata  = st_q.lock;
    assign smi_req    = st_q.smi;
endmodule

// File: rtl/cmos_lock_ram_chk.sv
module cmos_lock_ram_chk (
    input logic       clk,
    input logic       hard_rst_n,
    input logic       rtc_rst_n,
    input logic       sleep_state,
    input logic [1:0] cfg_rdata,
    input logic [7:0] sts_rdata,
    input logic       smi_req
);
    // R5: set lock bits persist until a reset
    assert_lock_sticky_R5: assert property (@(posedge clk)
        disable iff (!hard_rst_n || !rtc_rst_n)
        (cfg_rdata != 2'b00) |=> ((cfg_rdata & $past(cfg_rdata)) == $past(cfg_rdata)));

    // R7: SMI pulses last one cycle
    assert_smi_pulse_R7: assert property (@(posedge clk)
        disable iff (!hard_rst_n || !rtc_rst_n)
        smi_req |=> !smi_req);

    // R7: SMI only follows an awake cycle
    assert_smi_awake_R7: assert property (@(posedge clk)
        disable iff (!hard_rst_n || !rtc_rst_n)
        smi_req |-> !$past(sleep_state));

    // R6: an SMI always comes with the century flag
    assert_smi_sts_R6: assert property (@(posedge clk)
        disable iff (!hard_rst_n || !rtc_rst_n)
        smi_req |-> sts_rdata[7]);

    // R9: RTC-well reset defaults
    assert_rtc_reset_R9: assert property (@(posedge clk)
        !rtc_rst_n |=> (cfg_rdata == 2'b00 && !sts_rdata[7] && sts_rdata[2] && !smi_req));

    // R10: hard reset drops the locks
    assert_hard_reset_R10: assert property (@(posedge clk)
        !hard_rst_n |=> (cfg_rdata == 2'b00 && !smi_req));
endmodule

bind cmos_lock_ram cmos_lock_ram_chk u_chk (
    .clk         (clk),
    .hard_rst_n  (hard_rst_n),
    .rtc_rst_n   (rtc_rst_n),
    .sleep_state (sleep_state),
    .cfg_rdata   (cfg_rdata),
    .sts_rdata   (sts_rdata),
    .smi_req     (smi_req)
);

// File: tb/cmos_lock_ram_tb_top.sv
module cmos_lock_ram_tb_top;
    logic       clk = 1'b0;
    logic       hard_rst_n = 1'b0;
    logic       rtc_rst_n = 1'b0;
    logic       sleep_state = 1'b0;
    logic       idx_we = 1'b0;
    logic       data_we = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_wdata = '0;
    logic [1:0] cfg_rdata;
    logic       sts_we = 1'b0;
    logic [7:0] sts_wdata = '0;
    logic [7:0] sts_rdata;
    logic       smi_req;

    int  n_chk = 0;
    int  n_bad = 0;
    logic smi_seen;
    bit  finished = 0;

    always #4 clk = ~clk;

    cmos_lock_ram dut_i (
        .clk(clk), .hard_rst_n(hard_rst_n), .rtc_rst_n(rtc_rst_n),
        .sleep_state(sleep_state), .idx_we(idx_we), .data_we(data_we),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .sts_we(sts_we), .sts_wdata(sts_wdata), .sts_rdata(sts_rdata),
        .smi_req(smi_req)
    );

    // {is_read, index, data-or-expected}
    localparam int NVEC = 16;
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 8'h00, 8'h5A}, {1'b0, 8'h10, 8'hA5}, {1'b0, 8'h38, 8'h11},
        {1'b0, 8'h3F, 8'h22}, {1'b0, 8'h78, 8'h33}, {1'b0, 8'h7F, 8'h44},
        {1'b0, 8'h8A, 8'hC3}, {1'b0, 8'h09, 8'h99},
        {1'b1, 8'h00, 8'h5A}, {1'b1, 8'h10, 8'hA5}, {1'b1, 8'h38, 8'h11},
        {1'b1, 8'h3F, 8'h22}, {1'b1, 8'h78, 8'h33}, {1'b1, 8'h7F, 8'h44},
        {1'b1, 8'h0A, 8'hC3}, {1'b1, 8'h09, 8'h99}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_idx(input logic [7:0] i);
        @(negedge clk); idx_we = 1'b1; host_wdata = i;
        @(negedge clk); idx_we = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] d);
        @(negedge clk); data_we = 1'b1; host_wdata = d;
        @(negedge clk); data_we = 1'b0; smi_seen = smi_req;
    endtask

    task automatic cfg_write(input logic [1:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic sts_clear(input logic [7:0] m);
        @(negedge clk); sts_we = 1'b1; sts_wdata = m;
        @(negedge clk); sts_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] i, input logic [7:0] exp);
        set_idx(i);
        chk(req, host_rdata, exp);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rtc_rst_n = 1'b1; hard_rst_n = 1'b1;
        @(negedge clk);
        chk("R9 pwr flag after rtc reset", sts_rdata, 8'h04);
        chk("R9 locks after rtc reset", {6'b0, cfg_rdata}, 8'h00);
        chk("R7 no smi at reset", {7'b0, smi_req}, 8'h00);
        sts_clear(8'h04);
        chk("R8 pwr flag W1C", sts_rdata, 8'h00);

        // R1 table walk
        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][16]) rd_chk("R1 table read", VEC[v][15:8], VEC[v][7:0]);
            else begin
                set_idx(VEC[v][15:8]);
                wr_data(VEC[v][7:0]);
            end
        end

        // R6/R7 awake rollover
        set_idx(8'h09);
        wr_data(8'h00);
        chk("R7 smi on awake rollover", {7'b0, smi_seen}, 8'h01);
        chk("R6 century flag set", sts_rdata, 8'h80);
        @(negedge clk);
        chk("R7 smi one cycle", {7'b0, smi_req}, 8'h00);
        sts_clear(8'h7B);
        chk("R8 zero mask keeps flag", sts_rdata, 8'h80);
        sts_clear(8'h80);
        chk("R8 century W1C", sts_rdata, 8'h00);

        // R6/R7 sleeping rollover
        sleep_state = 1'b1;
        wr_data(8'h99);
        wr_data(8'h00);
        chk("R7 no smi while asleep", {7'b0, smi_seen}, 8'h00);
        chk("R6 flag set while asleep", sts_rdata, 8'h80);
        sleep_state = 1'b0;
        sts_clear(8'h80);

        // R6 near misses
        wr_data(8'h98);
        wr_data(8'h00);
        chk("R6 98->00 not rollover", sts_rdata, 8'h00);
        wr_data(8'h99);
        wr_data(8'h01);
        chk("R6 99->01 not rollover", sts_rdata, 8'h00);
        wr_data(8'h99);
        wr_data(8'h00);
        chk("R6 flag before hard reset", sts_rdata, 8'h80);

        // Window 0 lock
        cfg_write(2'b01);
        chk("R5 lock readback", {6'b0, cfg_rdata}, 8'h01);
        rd_chk("R4 locked low edge", 8'h38, 8'hFF);
        rd_chk("R4 locked high edge", 8'h3F, 8'hFF);
        rd_chk("R2 other window open", 8'h78, 8'h33);
        rd_chk("R2 outside index open", 8'h10, 8'hA5);
        set_idx(8'h38);
        wr_data(8'h55);
        cfg_write(2'b00);
        chk("R5 zero write ignored", {6'b0, cfg_rdata}, 8'h01);

        // R10 hard reset
        @(negedge clk); hard_rst_n = 1'b0;
        @(negedge clk); hard_rst_n = 1'b1;
        chk("R10 locks cleared", {6'b0, cfg_rdata}, 8'h00);
        chk("R10 status kept", sts_rdata, 8'h80);
        chk("R10 index cleared RAM kept", host_rdata, 8'h5A);
        rd_chk("R3 locked write dropped", 8'h38, 8'h11);

        // Window 1 lock, then R9
        cfg_write(2'b10);
        rd_chk("R4 window 1 masked", 8'h7F, 8'hFF);
        rd_chk("R2 window 0 open", 8'h38, 8'h11);
        @(negedge clk); rtc_rst_n = 1'b0;
        @(negedge clk); rtc_rst_n = 1'b1;
        chk("R9 locks cleared", {6'b0, cfg_rdata}, 8'h00);
        chk("R9 status defaults", sts_rdata, 8'h04);
        rd_chk("R9 RAM kept", 8'h7F, 8'h44);

        finish_run();
    end
endmodule